// File: doc/BRIEF.md
# Programmable Channel Clock Divider

This block turns a fast input clock into a slower one whose ratio is built from two separate 4-bit counts: one sets how many input cycles the output stays low, the other how many it stays high. One stage therefore covers every integer ratio from 2 to 32, with the duty cycle set by the split between the counts. A stage can instead pass the input clock straight through (divide-by-1), or hold its output at a static level.

A chip-level sync request freezes every stage at a programmed start level with its counter preloaded from a phase offset. When the request drops, all stages start together after a fixed latency, so outputs that share the same settings keep a known phase relationship. A stage can be told to ignore sync. Settings are written into a pending copy on an update strobe and applied only at the start of a period or while the stage is held, so the output never shows a clipped or stretched half-period.

Two stages may be chained. The second stage counts complete periods of the first, which gives ratios up to 1024. When only one stage is needed, the first one divides and the second is bypassed.

Top module: `chan_clk_divider`

## Requirements
- R1: With low count L and high count H (each 0..15), the output period is (L+1)+(H+1) input cycles, and the output stays high for H+1 of them.
- R2: With the bypass bit set on every stage, the output follows the input clock level (divide-by-1).
- R3: While sync_req is high and the stage's ignore-sync bit is clear, the output sits at the start level and does not toggle.
- R4: If the first rising input-clock edge that samples sync_req low is edge k, and the phase offset is 0, the first output transition follows edge k+SYNC_LAT (default 14). Until then the output shows the start level (start_hi bit: 1 = high, 0 = low).
- R5: A phase offset P postpones that first transition by P input cycles, to edge k+SYNC_LAT+P.
- R6: With the ignore-sync bit set, the stage keeps dividing while sync_req is high.
- R7: With the force bit set, the output is static: high if ignore-sync is also set, low otherwise.
- R8: Counts written with cfg_upd take effect only at the next low-to-high output transition (or while the stage is held), never inside the period that is running.
- R9: With both stages active, the output period is the product of the two stage ratios, and the output stays high for (H2+1) complete periods of the first stage.
- R10: During reset the output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_req | input | 1 | Chip-level sync request, active high |
| cfg_upd | input | 1 | Strobe that captures the cfg_* fields into the pending copy |
| cfg_lo | input | NUM_STAGES*4 | Low count per stage |
| cfg_hi | input | NUM_STAGES*4 | High count per stage |
| cfg_phase | input | NUM_STAGES*4 | Phase offset per stage |
| cfg_start_hi | input | NUM_STAGES | Start level per stage |
| cfg_bypass | input | NUM_STAGES | Bypass per stage |
| cfg_nosync | input | NUM_STAGES | Ignore sync per stage |
| cfg_force_hi | input | NUM_STAGES | Force static output per stage |
| clk_out | output | 1 | Divided clock |

## Verification
The assertions rely on the update strobe being a single-cycle pulse, on the configuration fields being stable whenever it is sampled, and on sync_req being driven synchronously to clk_in. The stimulus changes inputs only 2 ns after a falling edge. It drives configuration while sync is held, or at one planned mid-run cycle whose effect the scoreboard models. It never bypasses the first stage while the second one is dividing. Expected output levels come from a behavioural model of the counts, the latency and the pending-update rule, and are compared on every falling edge.

// File: rtl/chdiv_pkg.sv
`timescale 1ns/1ps
package chdiv_pkg;
   localparam int unsigned CNT_W = 4;

   typedef struct packed {
      logic [CNT_W-1:0] lo;
      logic [CNT_W-1:0] hi;
      logic [CNT_W-1:0] phase;
      logic             start_hi;
      logic             bypass;
      logic             nosync;
      logic             force_hi;
   } stage_cfg_t;
endpackage

// File: rtl/chdiv_sync_gate.sv
`timescale 1ns/1ps
module chdiv_sync_gate #(
   parameter int unsigned SYNC_LAT = 14
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_req,
   output logic hold
);
   localparam int unsigned LW = $clog2(SYNC_LAT + 1);

   logic [LW-1:0] lat;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= 1'b1;
         lat  <= '0;
      end else if (sync_req) begin
         hold <= 1'b1;
         lat  <= '0;
      end else if (hold) begin
         if (lat == LW'(SYNC_LAT - 1)) hold <= 1'b0;
         else                          lat  <= lat + 1'b1;
      end
   end

   AST_SYNC_SETS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      sync_req |=> hold); // R3
   AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !sync_req && lat != LW'(SYNC_LAT - 1)) |=> hold); // R4
endmodule

// File: rtl/chdiv_cfg_shadow.sv
`timescale 1ns/1ps
module chdiv_cfg_shadow
   import chdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       upd,
   input  stage_cfg_t cfg_new,
   input  logic       commit,
   output stage_cfg_t act,
   output stage_cfg_t pend,
   output logic       pend_v
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act    <= '0;
         pend   <= '0;
         pend_v <= 1'b0;
      end else begin
         if (commit) act <= pend;
         if (upd) begin
            pend   <= cfg_new;
            pend_v <= 1'b1;
         end else if (commit) begin
            pend_v <= 1'b0;
         end
      end
   end

   AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> (act == $past(act))); // R8
endmodule

// File: rtl/chdiv_stage.sv
`timescale 1ns/1ps
module chdiv_stage
   import chdiv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold_raw,
   input  logic       adv,
   input  logic       in_path,
   input  logic       cfg_upd,
   input  stage_cfg_t cfg_new,
   output logic       run_q,
   output logic       byp_act,
   output logic       stg_out
);
   stage_cfg_t       act;
   stage_cfg_t       pend;
   stage_cfg_t       use_c;
   logic             pend_v;
   logic [CNT_W-1:0] cnt;
   logic             q;
   logic             boundary;
   logic             commit;
   logic             held;

   chdiv_cfg_shadow u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .upd     (cfg_upd),
      .cfg_new (cfg_new),
      .commit  (commit),
      .act     (act),
      .pend    (pend),
      .pend_v  (pend_v)
   );

   // a period starts where the low phase expires
   always_comb begin
      boundary = adv && !act.bypass && !(hold_raw && !act.nosync)
                 && (cnt == '0) && !q;
      commit   = pend_v && (hold_raw || act.bypass || boundary);
      use_c    = commit ? pend : act;
      held     = (hold_raw && !use_c.nosync) || use_c.bypass;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q   <= 1'b0;
         cnt <= '0;
      end else if (held) begin
         q   <= use_c.start_hi;
         cnt <= use_c.phase;
      end else if (adv) begin
         if (cnt == '0) begin
            q   <= ~q;
            cnt <= q ? use_c.lo : use_c.hi;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   always_comb begin
      if (act.bypass)        stg_out = in_path;
      else if (act.force_hi) stg_out = act.nosync;
      else                   stg_out = q;
   end

   assign run_q   = q;
   assign byp_act = act.bypass;

   AST_TOGGLE_ON_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !held && cnt == '0) |=> (q != $past(q))); // R1
   AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !held && cnt != '0) |=> (q == $past(q))); // R1
   AST_HELD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      held |=> (q == $past(use_c.start_hi))); // R3
endmodule

// File: rtl/chan_clk_divider.sv
`timescale 1ns/1ps
module chan_clk_divider
   import chdiv_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 2,
   parameter int unsigned SYNC_LAT   = 14
) (
   input  logic                        clk_in,
   input  logic                        rst_n,
   input  logic                        sync_req,
   input  logic                        cfg_upd,
   input  logic [NUM_STAGES*CNT_W-1:0] cfg_lo,
   input  logic [NUM_STAGES*CNT_W-1:0] cfg_hi,
   input  logic [NUM_STAGES*CNT_W-1:0] cfg_phase,
   input  logic [NUM_STAGES-1:0]       cfg_start_hi,
   input  logic [NUM_STAGES-1:0]       cfg_bypass,
   input  logic [NUM_STAGES-1:0]       cfg_nosync,
   input  logic [NUM_STAGES-1:0]       cfg_force_hi,
   output logic                        clk_out
);
   localparam int unsigned LAST = NUM_STAGES - 1;

   generate
      if (NUM_STAGES < 1 || NUM_STAGES > 2) begin : g_bad_stages
         $error("NUM_STAGES must be 1 or 2");
      end
      if (SYNC_LAT < 2) begin : g_bad_lat
         $error("SYNC_LAT must be at least 2");
      end
   endgenerate

   logic hold;

   chdiv_sync_gate #(.SYNC_LAT(SYNC_LAT)) u_sync (
      .clk      (clk_in),
      .rst_n    (rst_n),
      .sync_req (sync_req),
      .hold     (hold)
   );

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_st
      stage_cfg_t cfg_i;
      logic       st_in;
      logic       st_adv;
      logic       st_q;
      logic       st_byp;
      logic       st_out;

      assign cfg_i.lo       = cfg_lo[i*CNT_W +: CNT_W];
      assign cfg_i.hi       = cfg_hi[i*CNT_W +: CNT_W];
      assign cfg_i.phase    = cfg_phase[i*CNT_W +: CNT_W];
      assign cfg_i.start_hi = cfg_start_hi[i];
      assign cfg_i.bypass   = cfg_bypass[i];
      assign cfg_i.nosync   = cfg_nosync[i];
      assign cfg_i.force_hi = cfg_force_hi[i];

      if (i == 0) begin : g_head
         assign st_in  = clk_in;
         assign st_adv = 1'b1;
      end else begin : g_chain
         logic prev_q_d;
         always_ff @(posedge clk_in) begin
            if (!rst_n) prev_q_d <= 1'b0;
            else        prev_q_d <= g_st[i-1].st_q;
         end
         assign st_in  = g_st[i-1].st_out;
         assign st_adv = g_st[i-1].st_byp | (g_st[i-1].st_q & ~prev_q_d);
      end

      chdiv_stage u_stage (
         .clk      (clk_in),
         .rst_n    (rst_n),
         .hold_raw (hold),
         .adv      (st_adv),
         .in_path  (st_in),
         .cfg_upd  (cfg_upd),
         .cfg_new  (cfg_i),
         .run_q    (st_q),
         .byp_act  (st_byp),
         .stg_out  (st_out)
      );
   end

   assign clk_out = g_st[LAST].st_out;
endmodule

// File: tb/chan_clk_divider_test.sv
`timescale 1ns/1ps
module chan_clk_divider_test;
   localparam int CLK_P = 10;
   localparam int NS    = 2;
   localparam int LAT   = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_req = 1'b1;
   logic cfg_upd = 1'b0;
   logic [NS*4-1:0] cfg_lo = '0, cfg_hi = '0, cfg_phase = '0;
   logic [NS-1:0] cfg_start_hi = '0, cfg_bypass = '0, cfg_nosync = '0, cfg_force_hi = '0;
   logic clk_out;

   int n_chk = 0;
   int n_bad = 0;
   bit exp_q[$];
   string cur_req = "R1";

   always #(CLK_P/2) clk = ~clk;

   chan_clk_divider #(.NUM_STAGES(NS), .SYNC_LAT(LAT)) uut (
      .clk_in(clk), .rst_n(rst_n), .sync_req(sync_req), .cfg_upd(cfg_upd),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_phase(cfg_phase),
      .cfg_start_hi(cfg_start_hi), .cfg_bypass(cfg_bypass),
      .cfg_nosync(cfg_nosync), .cfg_force_hi(cfg_force_hi), .clk_out(clk_out)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // monitor: compare one expected level per falling edge
   initial forever begin
      @(negedge clk); #1;
      if (exp_q.size() > 0) begin
         bit e;
         e = exp_q.pop_front();
         chk(clk_out == e, cur_req, int'(clk_out), int'(e));
      end
   end

   task automatic set_stage(input int s, input int lo, input int hi, input int ph,
                            input bit st, input bit byp, input bit ns, input bit fh);
      cfg_lo[s*4 +: 4] = 4'(lo);
      cfg_hi[s*4 +: 4] = 4'(hi);
      cfg_phase[s*4 +: 4] = 4'(ph);
      cfg_start_hi[s] = st;
      cfg_bypass[s] = byp;
      cfg_nosync[s] = ns;
      cfg_force_hi[s] = fh;
   endtask

   task automatic strobe();
      @(negedge clk); #2; cfg_upd = 1'b1;
      @(negedge clk); #2; cfg_upd = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   // driver: expected levels after each edge k+j
   task automatic push_run(input int n, input int lo, input int hi, input int ph,
                           input bit st, input int u, input int nlo, input int nhi);
      int ev;
      bit lvl;
      bit pend;
      ev = LAT + ph; lvl = st; pend = 1'b0;
      for (int j = 0; j < n; j++) begin
         if (j == ev) begin
            if (!lvl && pend) begin lo = nlo; hi = nhi; pend = 1'b0; end
            lvl = ~lvl;
            ev = j + (lvl ? hi : lo) + 1;
         end
         if (j == u) pend = 1'b1;
         exp_q.push_back(lvl);
      end
   endtask

   task automatic run_case(input string req, input int n, input int lo, input int hi,
                           input int ph, input bit st, input int u, input int nlo, input int nhi);
      cur_req = req;
      set_stage(0, lo, hi, ph, st, 1'b0, 1'b0, 1'b0);
      set_stage(1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      strobe();
      @(negedge clk); #2; sync_req = 1'b0;
      push_run(n, lo, hi, ph, st, u, nlo, nhi);
      if (u >= 0) begin
         repeat (u) begin @(negedge clk); #2; end
         cfg_lo[3:0] = 4'(nlo); cfg_hi[3:0] = 4'(nhi); cfg_upd = 1'b1;
         @(negedge clk); #2; cfg_upd = 1'b0;
      end
      while (exp_q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      #2; sync_req = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic count_rises(input int n, output int rises);
      bit prev;
      rises = 0;
      @(negedge clk); #1; prev = clk_out;
      for (int j = 0; j < n; j++) begin
         @(negedge clk); #1;
         if (clk_out && !prev) rises++;
         prev = clk_out;
      end
   endtask

   task automatic measure(output int per, output int hiw);
      bit prev;
      per = 0; hiw = 0;
      @(negedge clk); #1; prev = clk_out;
      while (!(clk_out && !prev)) begin prev = clk_out; @(negedge clk); #1; end
      prev = clk_out;
      do begin
         per++;
         if (clk_out) hiw++;
         prev = clk_out;
         @(negedge clk); #1;
      end while (!(clk_out && !prev) && per < 2000);
   endtask

   initial begin
      #(CLK_P * 100000);
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int r, per, hiw, ones;
      repeat (3) @(negedge clk);
      #1; chk(clk_out == 1'b0, "R10", int'(clk_out), 0);
      #1; rst_n = 1'b1;
      repeat (2) @(negedge clk);

      run_case("R1 R4 lo1 hi2", 50, 1, 2, 0, 1'b0, -1, 0, 0);
      run_case("R3 R5 phase3 start-high", 40, 0, 0, 3, 1'b1, -1, 0, 0);
      run_case("R1 div32", 110, 15, 15, 0, 1'b0, -1, 0, 0);
      run_case("R5 phase15", 60, 2, 1, 15, 1'b0, -1, 0, 0);
      run_case("R8 update mid-run", 80, 2, 2, 0, 1'b0, 20, 0, 4);

      // R2: divide-by-1
      set_stage(0, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      set_stage(1, 0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0);
      strobe();
      for (int j = 0; j < 4; j++) begin
         @(posedge clk); #1; chk(clk_out == 1'b1, "R2", int'(clk_out), 1);
         @(negedge clk); #1; chk(clk_out == 1'b0, "R2", int'(clk_out), 0);
      end

      // R6: sync ignored; R3: sync obeyed
      set_stage(0, 1, 1, 0, 1'b0, 1'b0, 1'b1, 1'b0);
      strobe();
      count_rises(60, r);
      chk(r >= 14 && r <= 16, "R6", r, 15);
      set_stage(0, 1, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      strobe();
      count_rises(40, r);
      chk(r == 0, "R3", r, 0);

      // R7: forced static output
      set_stage(0, 1, 1, 0, 1'b0, 1'b0, 1'b1, 1'b1);
      strobe();
      ones = 0;
      for (int j = 0; j < 20; j++) begin @(negedge clk); #1; ones += int'(clk_out); end
      chk(ones == 20, "R7 force with nosync", ones, 20);
      set_stage(0, 1, 1, 0, 1'b0, 1'b0, 1'b0, 1'b1);
      strobe();
      @(negedge clk); #2; sync_req = 1'b0;
      ones = 0;
      for (int j = 0; j < 40; j++) begin @(negedge clk); #1; ones += int'(clk_out); end
      chk(ones == 0, "R7 force without nosync", ones, 0);
      #1; sync_req = 1'b1;

      // R9: cascade 4 x 3
      set_stage(0, 1, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      set_stage(1, 0, 1, 0, 1'b0, 1'b0, 1'b0, 1'b0);
      strobe();
      @(negedge clk); #2; sync_req = 1'b0;
      repeat (60) @(negedge clk);
      measure(per, hiw);
      chk(per == 12, "R9 period", per, 12);
      chk(hiw == 8, "R9 high time", hiw, 8);
      measure(per, hiw);
      chk(per == 12, "R9 period repeat", per, 12);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule